// File: doc/BRIEF.md
# Line-Doubled Bitmap Plane Renderer

This block turns a linear pixel table into a picture. Every table word holds one 8-bit colour in R3G3B2 form, and the table is laid out row-major: bitmap pixel (column c, line l) sits at address l*W + c, where W is the bitmap width. The renderer does not compute x*y products. It keeps one running read address. That address advances while the raster is inside the active area and returns to zero on vertical sync.

The bitmap fills a raster twice its size in each direction. The address advances on every second active pixel, so each bitmap pixel covers two raster pixels. At the end of every even raster line the address steps back one bitmap line, so each bitmap line is drawn twice. The pixel memory answers one clock after the address, and the renderer delays its blank flag by the same clock to stay aligned. The 8-bit colour is widened to 8 bits per channel by repeating each channel's bit pattern, so that black maps to 0x00 and full scale maps to 0xFF. The result goes to a TMDS encoder.

Top module: `bitmap_plane_top`

## Requirements
- R1: During an active raster cycle on raster line y (counted from 0 after vertical sync) at active pixel x (counted from 0 in the line), `rd_addr` equals (y/2)*BMP_W + x/2, with integer division. With BMP_W=320, bitmap line 1 pixel 1 is address 321.
- R2: From the second blank cycle after a raster line until the next active cycle, `rd_addr` holds the start of the next line to be drawn, ((lines done)/2)*BMP_W. After an even line this value is a rewind by BMP_W.
- R3: A cycle with `vsync` high sets `rd_addr` to 0 from the next cycle on and restarts the line count at line 0.
- R4: The red output is {r,r,r[2:1]} and the green output is {g,g,g[2:1]}, where r and g are the 3-bit channel fields.
- R5: The blue output is the 2-bit field repeated four times. A channel field of all zeros gives 8'h00 and a field of all ones gives 8'hFF.
- R6: The field positions are: `rd_data[7:5]` red, `[4:2]` green, `[1:0]` blue. Red goes to `rgb[23:16]`, green to `rgb[15:8]` and blue to `rgb[7:0]`.
- R7: `rgb` is the expansion of the `rd_data` word read for the previous cycle's address when the previous cycle was active. When the previous cycle was blank, `rgb` is zero.
- R8: `blank` is high exactly when `active` was low in the previous cycle.
- R9: When the previous cycle's address was BMP_W*BMP_H or greater, `rgb` is zero.
- R10: While `rst_n` is low, `rd_addr` is 0, `rgb` is 0 and `blank` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| active | input | 1 | Raster is in the visible area this cycle |
| vsync | input | 1 | Vertical sync pulse, active high |
| rd_data | input | 8 | Pixel word from the table, valid one cycle after the address |
| rd_addr | output | ADDR_W | Pixel table read address |
| rgb | output | 24 | Expanded 8:8:8 colour, aligned with `blank` |
| blank | output | 1 | Active flag delayed by one cycle and inverted |

## Verification
The bench drives frames with random horizontal blanking lengths and a random colour key, and it checks every cycle against a model built from line and pixel counters.

- Line repetition: a design that skips the rewind, or rewinds after odd lines, shows addresses one bitmap line ahead on every second raster line.
- Pixel pairing: a design that advances the address on every active pixel doubles the address slope within a line.
- Early vertical sync: a vertical sync after an odd number of lines checks that the line parity restarts. A design that keeps the stale parity rewinds on the wrong lines for the whole next frame.
- Lines past the bitmap end: these must be dark. A design that drops the range gate shows colour there.
- Colour expansion: the first 256 addresses of every frame carry all 256 colour codes. Zero-padding or a swapped field shows up as a wrong channel byte.
- Blank alignment: a blank flag without the one-cycle delay disagrees with the data at every line edge.

// File: rtl/bmp_pkg.sv
// bmp_pkg: shared widths and the output colour type for the bitmap plane.
// Assumes R3G3B2 source colour and an 8-bit-per-channel sink.
package bmp_pkg;
    localparam int SRC_R_W  = 3;
    localparam int SRC_G_W  = 3;
    localparam int SRC_B_W  = 2;
    localparam int SRC_W    = SRC_R_W + SRC_G_W + SRC_B_W;
    localparam int CHAN_W   = 8;

    typedef struct packed {
        logic [CHAN_W-1:0] red;
        logic [CHAN_W-1:0] green;
        logic [CHAN_W-1:0] blue;
    } rgb_t;
endpackage

// File: rtl/bmp_addr_gen.sv
// bmp_addr_gen: running read address for a line-doubled bitmap.
// Advances on every second active pixel, rewinds one bitmap line after each
// even raster line, clears on vsync. Assumes 2*BMP_W active pixels per line
// and vsync only while active is low.
module bmp_addr_gen #(
    parameter int BMP_W  = 320,
    parameter int BMP_H  = 240,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              vsync_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              in_range_o
);
    localparam int                TOTAL     = BMP_W * BMP_H;
    localparam logic [ADDR_W-1:0] LINE_STEP = ADDR_W'(BMP_W);
    localparam logic [ADDR_W-1:0] ADDR_LAST = '1;
    localparam logic [ADDR_W-1:0] ADDR_END  = ADDR_W'(TOTAL);

    logic [ADDR_W-1:0] addr_q;
    logic              phase_q;     // 1 on the second raster pixel of a pair
    logic              odd_line_q;  // 1 while drawing the repeat of a line
    logic              active_d_q;  // previous active, for line-end detect

    // Address, pixel-pair phase and line parity update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            phase_q    <= 1'b0;
            odd_line_q <= 1'b0;
            active_d_q <= 1'b0;
        end else if (vsync_i) begin
            addr_q     <= '0;
            phase_q    <= 1'b0;
            odd_line_q <= 1'b0;
            active_d_q <= 1'b0;
        end else begin
            active_d_q <= active_i;
            if (active_i) begin
                phase_q <= ~phase_q;
                if (phase_q && addr_q != ADDR_LAST) begin
                    addr_q <= addr_q + 1'b1;
                end
            end else if (active_d_q) begin
                phase_q    <= 1'b0;
                odd_line_q <= ~odd_line_q;
                if (!odd_line_q) begin
                    addr_q <= addr_q - LINE_STEP;
                end
            end
        end
    end

    // Range flag for the dark-beyond-end rule.
    always_comb in_range_o = (addr_q < ADDR_END);

    assign addr_o = addr_q;

    assert_vsync_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_i |=> (addr_q == '0));

    assert_hold_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !active_d_q && !vsync_i) |=> $stable(addr_q));

    assert_pair_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !vsync_i && !phase_q) |=> $stable(addr_q));
endmodule

// File: rtl/bmp_chan_expand.sv
// bmp_chan_expand: widens one colour channel by repeating its bit pattern,
// MSB first, until OUT_W bits are filled. Purely combinational.
module bmp_chan_expand #(
    parameter int IN_W  = 3,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  chan_i,
    output logic [OUT_W-1:0] chan_o
);
    // Each output bit takes the source bit at its position modulo IN_W.
    for (genvar i = 0; i < OUT_W; i++) begin : g_rep
        assign chan_o[OUT_W-1-i] = chan_i[IN_W-1-(i % IN_W)];
    end

    // Extremes must land on full scale (R5).
    always_comb begin
        if (chan_i == '1) assert_full_scale_R5: assert (chan_o == '1);
        if (chan_i == '0) assert_black_R5: assert (chan_o == '0);
    end
endmodule

// File: rtl/bmp_color_expand.sv
// bmp_color_expand: splits an R3G3B2 word into channels and widens each.
// Assumes red in the top bits, blue in the bottom bits.
module bmp_color_expand
    import bmp_pkg::*;
(
    input  logic [SRC_W-1:0] pix_i,
    output rgb_t             rgb_o
);
    localparam int B_LO = 0;
    localparam int G_LO = SRC_B_W;
    localparam int R_LO = SRC_B_W + SRC_G_W;

    bmp_chan_expand #(.IN_W(SRC_R_W), .OUT_W(CHAN_W)) u_red (
        .chan_i (pix_i[R_LO +: SRC_R_W]),
        .chan_o (rgb_o.red)
    );
    bmp_chan_expand #(.IN_W(SRC_G_W), .OUT_W(CHAN_W)) u_green (
        .chan_i (pix_i[G_LO +: SRC_G_W]),
        .chan_o (rgb_o.green)
    );
    bmp_chan_expand #(.IN_W(SRC_B_W), .OUT_W(CHAN_W)) u_blue (
        .chan_i (pix_i[B_LO +: SRC_B_W]),
        .chan_o (rgb_o.blue)
    );
endmodule

// File: rtl/bmp_out_stage.sv
// bmp_out_stage: aligns blank and range with the one-cycle memory read and
// forces the colour to black outside the visible, in-range pixels.
module bmp_out_stage
    import bmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic in_range_i,
    input  rgb_t color_i,
    output rgb_t rgb_o,
    output logic blank_o
);
    logic active_d_q;
    logic range_d_q;

    // Delay the qualifiers by the read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_d_q <= 1'b0;
            range_d_q  <= 1'b0;
        end else begin
            active_d_q <= active_i;
            range_d_q  <= in_range_i;
        end
    end

    // Gate the colour with the delayed qualifiers.
    always_comb rgb_o = (active_d_q && range_d_q) ? color_i : '0;

    assign blank_o = ~active_d_q;

    assert_blank_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> blank_o);

    assert_blank_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |=> !blank_o);

    assert_blank_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (rgb_o == '0));
endmodule

// File: rtl/bitmap_plane_top.sv
// bitmap_plane_top: line-doubled bitmap renderer. Issues pixel table reads,
// expects data one clock later, and outputs the expanded colour with a
// matching blank flag.
module bitmap_plane_top
    import bmp_pkg::*;
#(
    parameter int BMP_W = 320,
    parameter int BMP_H = 240,
    localparam int ADDR_W = $clog2(BMP_W * BMP_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              vsync,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [23:0]       rgb,
    output logic              blank
);
    localparam int TOTAL = BMP_W * BMP_H;

    logic in_range;
    rgb_t color;
    rgb_t rgb_s;

    bmp_addr_gen #(.BMP_W(BMP_W), .BMP_H(BMP_H), .ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .vsync_i    (vsync),
        .addr_o     (rd_addr),
        .in_range_o (in_range)
    );

    bmp_color_expand u_expand (
        .pix_i (rd_data),
        .rgb_o (color)
    );

    bmp_out_stage u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .in_range_i (in_range),
        .color_i    (color),
        .rgb_o      (rgb_s),
        .blank_o    (blank)
    );

    assign rgb = rgb_s;

    assert_past_end_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr) >= TOTAL) |=> (rgb == '0));
endmodule

// File: tb/bitmap_plane_top_test.sv
module bitmap_plane_top_test;
    localparam int W      = 40;
    localparam int H      = 30;
    localparam int TOTAL  = W * H;
    localparam int AW     = $clog2(TOTAL);
    localparam int LIMIT  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          active = 1'b0;
    logic          vsync = 1'b0;
    logic [7:0]    rd_data;
    logic [AW-1:0] rd_addr;
    logic [23:0]   rgb;
    logic          blank;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    bit   done = 0;
    logic [7:0] key = 8'h00;
    bit   prev_act = 0;
    int   prev_addr = 0;
    int   ln = 0;

    bitmap_plane_top #(.BMP_W(W), .BMP_H(H)) uut (
        .clk(clk), .rst_n(rst_n), .active(active), .vsync(vsync),
        .rd_data(rd_data), .rd_addr(rd_addr), .rgb(rgb), .blank(blank)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input int a);
        logic [15:0] av = 16'(a);
        return av[7:0] ^ key;
    endfunction

    function automatic logic [23:0] expand(input logic [7:0] d);
        return {d[7:5], d[7:5], d[7:6], d[4:2], d[4:2], d[4:3], {4{d[1:0]}}};
    endfunction

    // Synchronous-read pixel table model
    always @(posedge clk) rd_data <= pat(int'(rd_addr));

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h (line %0d)", tag, act, exp, ln);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // kind: 0 none, 1 R1 exact, 2 R2 hold, 3 R3 zero
    task automatic step(input bit a, input bit v, input int kind, input int exp_addr);
        logic [23:0] e;
        string t;
        @(posedge clk); #1;
        active = a; vsync = v;
        @(negedge clk);
        check("R8 blank", int'(blank), int'(!prev_act));
        if (prev_act && prev_addr < TOTAL) begin
            e = expand(pat(prev_addr)); t = "";
        end else begin
            e = 24'h0; t = prev_act ? "R9 " : "R7 ";
        end
        check({t, "R4 R6 red"},   int'(rgb[23:16]), int'(e[23:16]));
        check({t, "R4 R6 green"}, int'(rgb[15:8]),  int'(e[15:8]));
        check({t, "R5 R6 blue"},  int'(rgb[7:0]),   int'(e[7:0]));
        if (kind == 1) check("R1 addr", int'(rd_addr), exp_addr);
        if (kind == 2) check("R2 hold", int'(rd_addr), exp_addr);
        if (kind == 3) check("R3 vsync clear", int'(rd_addr), 0);
        prev_act  = a;
        prev_addr = exp_addr;
    endtask

    task automatic do_vsync();
        key = 8'($urandom);
        step(0, 1, 0, 0);
        step(0, 1, 3, 0);
        ln = 0;
        step(0, 0, 3, 0);
        step(0, 0, 3, 0);
    endtask

    task automatic do_line();
        int hb;
        for (int x = 0; x < 2 * W; x++) begin
            // e.g. line 2 pixel 2: bitmap line 1 pixel 1 -> W+1 (R1)
            step(1, 0, 1, (ln / 2) * W + x / 2);
        end
        ln++;
        hb = 2 + int'($urandom % 8);
        for (int k = 0; k < hb; k++) begin
            step(0, 0, (k == 0) ? 0 : 2, (ln / 2) * W);
        end
    endtask

    task automatic do_frame(input int lines);
        do_vsync();
        for (int l = 0; l < lines; l++) do_line();
    endtask

    initial begin
        void'($urandom(32'd2024));
        rd_data = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset addr", int'(rd_addr), 0);
        check("R10 reset rgb", int'(rgb), 0);
        check("R10 reset blank", int'(blank), 1);
        @(posedge clk); #1 rst_n = 1'b1;
        step(0, 0, 2, 0);
        // Full frames with random blanking and colour keys
        for (int f = 0; f < 4; f++) do_frame(2 * H);
        // Early vsync after an odd number of lines: parity must restart
        do_frame(3);
        do_frame(2 * H);
        // Extra lines beyond the bitmap end must stay dark
        do_frame(2 * H + 4);
        do_frame(5);
        step(0, 0, 2, (ln / 2) * W);
        summary();
    end

    initial begin
        wait (cyc >= LIMIT);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, LIMIT);
        summary();
    end
endmodule